// File: doc/BRIEF.md
# Address Translation Front End

This block sits in front of the translation lookaside buffers and decides, for every memory access, which of three routes the virtual address takes. With translation switched off the address is handed back unchanged with every permission granted. With translation on, a kernel access whose 256 MB segment is flagged for direct mapping is relocated by a 4-bit base taken from a nibble-packed table held in two 32-bit registers; that route never faults. Every other access is sent to a page lookup, which is a request/response exchange with an external TLB.

Bypass and segment results come back in the same cycle as the request. A paged access raises a TLB request from the next cycle and holds it until the TLB pulses done. The fault flag, physical address and permissions from the TLB are forwarded in that same cycle. Only one paged access is outstanding at a time, and the block deasserts its ready output while one is in flight. Execute accesses use the instruction TLB and data accesses use the data TLB.

Top module: `atf_xlate_front`

## Requirements
- R1: Translation is on when bit 2 or bit 3 of `gc_cfg_i` is set. When it is off, an accepted request answers in the same cycle with `rsp_paddr_o` equal to the virtual address, `rsp_fault_o` low and `rsp_perm_o` = 3'b111, and no TLB request is raised.
- R2: With translation on, segment mode applies when the access is a kernel access (`req_user_i` = 0) and bit S of `mm_cfg_i` is set, where S is virtual address bits [31:28]. With that bit clear, the access goes to the page lookup.
- R3: In segment mode the response arrives in the same cycle, with no fault and `rsp_perm_o` = 3'b111. Bits [27:0] of the physical address come from the virtual address. Bits [31:28] hold nibble S mod 8 (at bits 4·(S mod 8)+3 down to 4·(S mod 8)) of `seg_base_lo_i` for S < 8, or of `seg_base_hi_i` for S ≥ 8.
- R4: A user access (`req_user_i` = 1) with translation on always goes to the page lookup, whatever `mm_cfg_i` holds.
- R5: A paged request accepted in cycle n drives `tlb_req_o` high from cycle n+1 through the cycle in which `tlb_done_i` is high. While it is high, `tlb_vaddr_o`, `tlb_type_o`, `tlb_itlb_o` and `tlb_user_o` hold the captured request. `tlb_req_o` is low in the cycle after done.
- R6: The access type is 0 read, 1 write, 2 execute, and code 3 is handled as a read. `tlb_type_o` carries the normalised code. `tlb_itlb_o` is 1 only for execute accesses.
- R7: In a cycle where `tlb_req_o` and `tlb_done_i` are both high, `rsp_valid_o` is high and carries `tlb_fault_i`, `tlb_paddr_i` and `tlb_perm_i`. A `tlb_done_i` pulse while no request is outstanding produces no response.
- R8: `req_ready_o` is low exactly while a paged request is outstanding. A request presented then is not accepted and produces no response.
- R9: After reset, `req_ready_o` is high and `tlb_req_o` and `rsp_valid_o` are low.
- R10: With translation off, the segment mode flags in `mm_cfg_i` have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Access request present |
| req_ready_o | output | 1 | Request can be accepted |
| req_vaddr_i | input | 32 | Virtual address |
| req_type_i | input | 2 | 0 read, 1 write, 2 execute, 3 read |
| req_user_i | input | 1 | 1 for user access, 0 for kernel |
| gc_cfg_i | input | 32 | Global configuration; bits [3:2] enable translation |
| mm_cfg_i | input | 32 | Bits [15:0] flag segments for direct mapping |
| seg_base_lo_i | input | 32 | Base nibbles for segments 0 to 7 |
| seg_base_hi_i | input | 32 | Base nibbles for segments 8 to 15 |
| tlb_req_o | output | 1 | Page lookup outstanding |
| tlb_vaddr_o | output | 32 | Address under lookup |
| tlb_type_o | output | 2 | Normalised access type |
| tlb_user_o | output | 1 | User flag of lookup |
| tlb_itlb_o | output | 1 | 1 selects the instruction TLB, 0 the data TLB |
| tlb_done_i | input | 1 | Lookup finished |
| tlb_fault_i | input | 1 | Lookup failed |
| tlb_paddr_i | input | 32 | Physical address from lookup |
| tlb_perm_i | input | 3 | Permissions from lookup {exec, write, read} |
| rsp_valid_o | output | 1 | Result present |
| rsp_paddr_o | output | 32 | Physical address |
| rsp_fault_o | output | 1 | Translation fault |
| rsp_perm_o | output | 3 | Permissions {exec, write, read} |

## Verification
The assertions check several properties on every cycle. Pass-through is exact and fault-free when translation is off. Segment results never fault and keep the low 28 address bits. A user access always starts a lookup. The captured request stays stable while the lookup waits. The ready signal is low during a lookup, the TLB choice matches the access type, and the TLB result is forwarded on done. The base nibble picked for each of the sixteen segments needs the bench to sweep every segment against its own base table. The bench scenarios also show that stray done pulses are ignored, that type code 3 collapses to a read, and how done latencies from zero upward interleave with held-off requests.

// File: rtl/atf_pkg.sv
package atf_pkg;
  typedef enum logic [1:0] {
    ACC_READ  = 2'd0,
    ACC_WRITE = 2'd1,
    ACC_EXEC  = 2'd2
  } acc_e;

  localparam int PERM_W = 3;
  localparam logic [PERM_W-1:0] PERM_ALL = '1;

  function automatic acc_e norm_acc(input logic [1:0] code);
    case (code)
      2'd1:    return ACC_WRITE;
      2'd2:    return ACC_EXEC;
      default: return ACC_READ;
    endcase
  endfunction
endpackage

// File: rtl/atf_route.sv
module atf_route
  import atf_pkg::*;
#(
  parameter int EN_LSB = 2,
  parameter int EN_W   = 2
) (
  input  logic [EN_W-1:0] en_field_i,
  input  logic [1:0]      type_i,
  output logic            xlate_en_o,
  output acc_e            acc_o,
  output logic            itlb_o
);
  assign xlate_en_o = |en_field_i;
  assign acc_o      = norm_acc(type_i);
  assign itlb_o     = (acc_o == ACC_EXEC);
endmodule

// File: rtl/atf_seg_map.sv
module atf_seg_map #(
  parameter int VA_W  = 32,
  parameter int SEG_W = 4,
  localparam int NSEG   = 1 << SEG_W,
  localparam int HALF   = NSEG / 2,
  localparam int BASE_W = HALF * SEG_W
) (
  input  logic [VA_W-1:0]   vaddr_i,
  input  logic              user_i,
  input  logic [NSEG-1:0]   seg_en_i,
  input  logic [BASE_W-1:0] base_lo_i,
  input  logic [BASE_W-1:0] base_hi_i,
  output logic              seg_hit_o,
  output logic [VA_W-1:0]   seg_paddr_o
);
  logic [SEG_W-1:0] seg_idx;
  logic [SEG_W-1:0] base_tbl [NSEG];

  assign seg_idx = vaddr_i[VA_W-1 -: SEG_W];

  for (genvar g = 0; g < HALF; g++) begin : g_tbl
    assign base_tbl[g]        = base_lo_i[g*SEG_W +: SEG_W];
    assign base_tbl[g + HALF] = base_hi_i[g*SEG_W +: SEG_W];
  end

  assign seg_hit_o   = !user_i && seg_en_i[seg_idx];
  assign seg_paddr_o = {base_tbl[seg_idx], vaddr_i[VA_W-SEG_W-1:0]};
endmodule

// File: rtl/atf_page_ctl.sv
module atf_page_ctl
  import atf_pkg::*;
#(
  parameter int VA_W = 32
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            start_i,
  input  logic [VA_W-1:0] vaddr_i,
  input  acc_e            acc_i,
  input  logic            itlb_i,
  input  logic            user_i,
  input  logic            done_i,
  output logic            busy_o,
  output logic            finish_o,
  output logic [VA_W-1:0] tlb_vaddr_o,
  output acc_e            tlb_acc_o,
  output logic            tlb_itlb_o,
  output logic            tlb_user_o
);
  logic            pend_q;
  logic [VA_W-1:0] va_q;
  acc_e            acc_q;
  logic            itlb_q;
  logic            user_q;

  assign finish_o = pend_q && done_i;
  assign busy_o   = pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= 1'b0;
      va_q   <= '0;
      acc_q  <= ACC_READ;
      itlb_q <= 1'b0;
      user_q <= 1'b0;
    end else if (finish_o) begin
      pend_q <= 1'b0;
    end else if (start_i && !pend_q) begin
      pend_q <= 1'b1;
      va_q   <= vaddr_i;
      acc_q  <= acc_i;
      itlb_q <= itlb_i;
      user_q <= user_i;
    end
  end

  assign tlb_vaddr_o = va_q;
  assign tlb_acc_o   = acc_q;
  assign tlb_itlb_o  = itlb_q;
  assign tlb_user_o  = user_q;
endmodule

// File: rtl/atf_xlate_front.sv
module atf_xlate_front
  import atf_pkg::*;
#(
  parameter int VA_W   = 32,
  parameter int SEG_W  = 4,
  parameter int CFG_W  = 32,
  parameter int EN_LSB = 2,
  parameter int EN_W   = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [VA_W-1:0]   req_vaddr_i,
  input  logic [1:0]        req_type_i,
  input  logic              req_user_i,
  input  logic [CFG_W-1:0]  gc_cfg_i,
  input  logic [CFG_W-1:0]  mm_cfg_i,
  input  logic [CFG_W-1:0]  seg_base_lo_i,
  input  logic [CFG_W-1:0]  seg_base_hi_i,
  output logic              tlb_req_o,
  output logic [VA_W-1:0]   tlb_vaddr_o,
  output logic [1:0]        tlb_type_o,
  output logic              tlb_user_o,
  output logic              tlb_itlb_o,
  input  logic              tlb_done_i,
  input  logic              tlb_fault_i,
  input  logic [VA_W-1:0]   tlb_paddr_i,
  input  logic [PERM_W-1:0] tlb_perm_i,
  output logic              rsp_valid_o,
  output logic [VA_W-1:0]   rsp_paddr_o,
  output logic              rsp_fault_o,
  output logic [PERM_W-1:0] rsp_perm_o
);
  localparam int NSEG   = 1 << SEG_W;
  localparam int BASE_W = (NSEG / 2) * SEG_W;

  logic            xlate_en, itlb, seg_hit, busy, finish, accept, direct;
  acc_e            acc, tlb_acc;
  logic [VA_W-1:0] seg_paddr;
  logic            unused_cfg;

  assign unused_cfg = ^{gc_cfg_i, mm_cfg_i, seg_base_lo_i, seg_base_hi_i};

  atf_route #(.EN_LSB(EN_LSB), .EN_W(EN_W)) u_route (
    .en_field_i (gc_cfg_i[EN_LSB +: EN_W]),
    .type_i     (req_type_i),
    .xlate_en_o (xlate_en),
    .acc_o      (acc),
    .itlb_o     (itlb)
  );

  atf_seg_map #(.VA_W(VA_W), .SEG_W(SEG_W)) u_seg (
    .vaddr_i     (req_vaddr_i),
    .user_i      (req_user_i),
    .seg_en_i    (mm_cfg_i[NSEG-1:0]),
    .base_lo_i   (seg_base_lo_i[BASE_W-1:0]),
    .base_hi_i   (seg_base_hi_i[BASE_W-1:0]),
    .seg_hit_o   (seg_hit),
    .seg_paddr_o (seg_paddr)
  );

  assign req_ready_o = !busy;
  assign accept      = req_valid_i && !busy;
  assign direct      = !xlate_en || seg_hit;

  atf_page_ctl #(.VA_W(VA_W)) u_page (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (accept && !direct),
    .vaddr_i     (req_vaddr_i),
    .acc_i       (acc),
    .itlb_i      (itlb),
    .user_i      (req_user_i),
    .done_i      (tlb_done_i),
    .busy_o      (busy),
    .finish_o    (finish),
    .tlb_vaddr_o (tlb_vaddr_o),
    .tlb_acc_o   (tlb_acc),
    .tlb_itlb_o  (tlb_itlb_o),
    .tlb_user_o  (tlb_user_o)
  );

  assign tlb_req_o  = busy;
  assign tlb_type_o = tlb_acc;

  // finish and a direct accept are exclusive: ready is low while busy
  assign rsp_valid_o = (accept && direct) || finish;
  assign rsp_fault_o = finish && tlb_fault_i;
  assign rsp_perm_o  = finish ? tlb_perm_i : PERM_ALL;
  always_comb begin
    if (finish)        rsp_paddr_o = tlb_paddr_i;
    else if (xlate_en) rsp_paddr_o = seg_paddr;
    else               rsp_paddr_o = req_vaddr_i;
  end
endmodule

// File: rtl/atf_xlate_front_chk.sv
module atf_xlate_front_chk #(
  parameter int VA_W = 32
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            req_valid_i,
  input logic            req_ready_o,
  input logic [VA_W-1:0] req_vaddr_i,
  input logic [1:0]      req_type_i,
  input logic            req_user_i,
  input logic [31:0]     gc_cfg_i,
  input logic [31:0]     mm_cfg_i,
  input logic            tlb_req_o,
  input logic [VA_W-1:0] tlb_vaddr_o,
  input logic [1:0]      tlb_type_o,
  input logic            tlb_user_o,
  input logic            tlb_itlb_o,
  input logic            tlb_done_i,
  input logic            tlb_fault_i,
  input logic [VA_W-1:0] tlb_paddr_i,
  input logic [2:0]      tlb_perm_i,
  input logic            rsp_valid_o,
  input logic [VA_W-1:0] rsp_paddr_o,
  input logic            rsp_fault_o,
  input logic [2:0]      rsp_perm_o
);
  logic en, acc_ok, seg_on;
  assign en     = gc_cfg_i[2] || gc_cfg_i[3];
  assign acc_ok = req_valid_i && req_ready_o;
  assign seg_on = en && !req_user_i && mm_cfg_i[req_vaddr_i[VA_W-1 -: 4]];

  p_passthru_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_ok && !en |-> rsp_valid_o && !rsp_fault_o && rsp_paddr_o == req_vaddr_i && rsp_perm_o == 3'b111);

  p_seg_no_fault_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_ok && seg_on |-> rsp_valid_o && !rsp_fault_o && rsp_paddr_o[VA_W-5:0] == req_vaddr_i[VA_W-5:0]);

  p_user_paged_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_ok && en && req_user_i |=> tlb_req_o);

  p_req_held_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tlb_req_o && !tlb_done_i |=> tlb_req_o && $stable(tlb_vaddr_o) && $stable(tlb_type_o)
                                 && $stable(tlb_itlb_o) && $stable(tlb_user_o));

  p_release_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tlb_req_o && tlb_done_i |=> !tlb_req_o);

  p_itlb_sel_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tlb_req_o |-> tlb_itlb_o == (tlb_type_o == 2'd2) && tlb_type_o != 2'd3);

  p_forward_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tlb_req_o && tlb_done_i |-> rsp_valid_o && rsp_fault_o == tlb_fault_i
                                && rsp_paddr_o == tlb_paddr_i && rsp_perm_o == tlb_perm_i);

  p_busy_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tlb_req_o |-> !req_ready_o);
endmodule

bind atf_xlate_front atf_xlate_front_chk #(.VA_W(VA_W)) u_chk (.*);

// File: tb/atf_xlate_front_tb.sv
module atf_xlate_front_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_valid_i = 1'b0;
  logic        req_ready_o;
  logic [31:0] req_vaddr_i = '0;
  logic [1:0]  req_type_i = '0;
  logic        req_user_i = 1'b0;
  logic [31:0] gc_cfg_i = '0, mm_cfg_i = '0, seg_base_lo_i = '0, seg_base_hi_i = '0;
  logic        tlb_req_o;
  logic [31:0] tlb_vaddr_o;
  logic [1:0]  tlb_type_o;
  logic        tlb_user_o, tlb_itlb_o;
  logic        tlb_done_i = 1'b0, tlb_fault_i = 1'b0;
  logic [31:0] tlb_paddr_i = '0;
  logic [2:0]  tlb_perm_i = '0;
  logic        rsp_valid_o;
  logic [31:0] rsp_paddr_o;
  logic        rsp_fault_o;
  logic [2:0]  rsp_perm_o;

  atf_xlate_front u_dut (.*);

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  int n_chk = 0, n_err = 0;
  bit          m_pend = 0;
  logic [31:0] m_va;
  int          m_ty;
  bit          m_user;
  int          lat = 0;
  bit          stray = 0;

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // one clock: stub TLB, compare at negedge+1, advance model at posedge
  task automatic cyc();
    bit en, acc, seg, direct, done, exp_rv;
    logic [3:0] s, nib;
    logic [31:0] exp_pa;
    logic exp_f;
    logic [2:0] exp_perm;
    string tag;
    done = m_pend ? (lat == 0) : stray;
    tlb_done_i = done;
    if (done) begin
      tlb_paddr_i = $urandom; tlb_fault_i = 1'($urandom); tlb_perm_i = 3'($urandom);
    end
    #1;
    en = gc_cfg_i[2] | gc_cfg_i[3];
    acc = req_valid_i && !m_pend;
    s = req_vaddr_i[31:28];
    nib = 4'((s < 8 ? seg_base_lo_i : seg_base_hi_i) >> (32'(s % 8) * 4));
    seg = en && !req_user_i && mm_cfg_i[s];
    direct = !en || seg;
    exp_rv = (acc && direct) || (m_pend && done);
    tag = (acc && !en) ? "R1" : (acc && seg) ? "R3" : "R7";
    if (m_pend && done) begin
      exp_pa = tlb_paddr_i; exp_f = tlb_fault_i; exp_perm = tlb_perm_i;
    end else begin
      exp_pa = en ? {nib, req_vaddr_i[27:0]} : req_vaddr_i; exp_f = 0; exp_perm = 3'b111;
    end
    chk("R8", "req_ready", 32'(req_ready_o), 32'(!m_pend));
    chk(tag, "rsp_valid", 32'(rsp_valid_o), 32'(exp_rv));
    if (exp_rv) begin
      chk(tag, "rsp_paddr", rsp_paddr_o, exp_pa);
      chk(tag, "rsp_fault", 32'(rsp_fault_o), 32'(exp_f));
      chk(tag, "rsp_perm", 32'(rsp_perm_o), 32'(exp_perm));
    end
    chk("R5", "tlb_req", 32'(tlb_req_o), 32'(m_pend));
    if (m_pend) begin
      chk("R5", "tlb_vaddr", tlb_vaddr_o, m_va);
      chk("R5", "tlb_user", 32'(tlb_user_o), 32'(m_user));
      chk("R6", "tlb_type", 32'(tlb_type_o), 32'(m_ty));
      chk("R6", "tlb_itlb", 32'(tlb_itlb_o), 32'(m_ty == 2));
    end
    @(posedge clk_i);
    if (m_pend && done) m_pend = 0;
    else if (m_pend) lat--;
    else if (acc && !direct) begin
      m_pend = 1; m_va = req_vaddr_i; m_user = req_user_i;
      m_ty = (req_type_i == 2'd3) ? 0 : int'(req_type_i);
    end
    @(negedge clk_i);
  endtask

  task automatic issue(logic [31:0] va, logic [1:0] ty, bit user, int l);
    req_valid_i = 1; req_vaddr_i = va; req_type_i = ty; req_user_i = user;
    if (!m_pend) lat = l;
    cyc();
    req_valid_i = 0;
  endtask

  task automatic drain();
    while (m_pend) cyc();
    cyc();
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_err++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    // R9: reset state
    repeat (2) @(negedge clk_i);
    chk("R9", "ready in reset", 32'(req_ready_o), 1);
    chk("R9", "tlb_req in reset", 32'(tlb_req_o), 0);
    chk("R9", "rsp_valid in reset", 32'(rsp_valid_o), 0);
    rst_ni = 1;
    cyc();
    seg_base_lo_i = 32'h13579BDF;
    seg_base_hi_i = 32'h2468ACE0;
    // R1, R10: translation off, all segment flags set
    mm_cfg_i = 32'h0000FFFF;
    for (int t = 0; t < 4; t++) issue(32'h9ABC_0123 + t, 2'(t), t[0], 0);
    // R1: each enable bit alone
    gc_cfg_i = 32'h4;
    // R2, R3: every segment, kernel
    for (int s = 0; s < 16; s++) issue({4'(s), 28'h5A5_1234}, 2'd0, 0, 0);
    gc_cfg_i = 32'h8;
    for (int s = 0; s < 16; s++) issue({4'(s), 28'hFFF_FFFF}, 2'd2, 0, 0);
    // R2: flag clear goes paged; R6 exec selects instruction TLB
    mm_cfg_i = 32'h000000F0;
    issue(32'h2000_4000, 2'd2, 0, 2); drain();
    issue(32'h5000_4000, 2'd1, 0, 0); cyc();
    // R4: user access in flagged segment goes paged
    issue(32'h5000_8000, 2'd0, 1, 1); drain();
    // R6 all type codes; R8 request held during lookup
    for (int t = 0; t < 4; t++) begin
      issue(32'h0100_0000 * t + 32'h2000, 2'(t), 1, t);
      req_valid_i = 1;
      drain();
      req_valid_i = 0;
    end
    // R7: stray done while idle
    stray = 1; cyc(); cyc(); stray = 0;
    // mixed traffic
    for (int i = 0; i < 3000; i++) begin
      if (i % 200 == 0) begin
        gc_cfg_i = $urandom; mm_cfg_i = $urandom;
        seg_base_lo_i = $urandom; seg_base_hi_i = $urandom;
      end
      req_valid_i = 1'($urandom); req_vaddr_i = $urandom;
      req_type_i = 2'($urandom); req_user_i = 1'($urandom);
      stray = 1'($urandom);
      if (!m_pend) lat = $urandom_range(0, 3);
      cyc();
    end
    stray = 0; req_valid_i = 0;
    drain();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule